// File: doc/BRIEF.md
# Multi-Target Interrupt Claim Controller

This block collects level-sensitive interrupt requests from a set of numbered sources and routes them to several targets, typically processor cores. Source identifier 0 is reserved and means "no source". Each source passes through its own gateway. The gateway turns a held level into a single request, sets that source's pending bit, and then waits for a completion before it will request again.

Each source has a programmable priority. Each target has a bit array that enables individual sources and a priority threshold. For every target the controller picks the best source. This is the pending, enabled source with the highest nonzero priority, and a tie goes to the lowest identifier. The target's interrupt line is raised when that priority is strictly above the target's threshold.

Software uses one register per target for two jobs. Reading it claims the best source: the read returns the source's identifier and clears its pending bit. Writing an identifier to it completes that source and re-arms the source's gateway.

Each gateway is a two-state machine. In state GW_IDLE it takes the REQUEST transition to GW_INFLIGHT when its level input is high and the pending bit is clear. In GW_INFLIGHT it takes the COMPLETE transition back to GW_IDLE when its identifier is written to any target's claim register.

Register access uses a single-cycle port. Read data is combinational from the address, and write effects and claim side effects take place at the clock edge that ends the access. Register map, in byte offsets:
- Priority of source i: 4·i.
- Pending word: 0x1000.
- Enable word of target t: 0x2000 + 0x80·t.
- Threshold of target t: 0x200000 + 0x1000·t.
- Claim/complete of target t: 0x200004 + 0x1000·t.

In the pending and enable words, bit i stands for source i.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, every priority, enable word, threshold and pending bit is zero, every target line is low, and a claim read returns 0.
- R2: The priority register of source i (1..N) at offset 4·i holds the low PRIO_W bits written and reads the upper bits as zero, where PRIO_W = clog2(min(N, MAX_PRIO)+1). Offset 0 reads zero and ignores writes.
- R3: A source whose level input is high while its gateway is in GW_IDLE and its pending bit is clear sets bit i of the pending word at 0x1000 one clock later. No further request is made until the source is completed.
- R4: For each target, the claim candidate is the pending, enabled source with the highest priority. Among equal priorities, the lowest identifier wins.
- R5: A target's interrupt line is high exactly when its candidate's priority is strictly greater than the target's threshold at 0x200000 + 0x1000·t. The threshold holds PRIO_W bits.
- R6: A read of the claim register at 0x200004 + 0x1000·t returns the candidate's identifier and clears its pending bit. If there is no candidate, the read returns 0 and no pending bit changes.
- R7: Writing identifier i (1..N) to any claim register returns gateway i to GW_IDLE. If its level is still high, the pending bit is set again one clock after the completing write. Identifiers 0 and above N are ignored.
- R8: The enable word of target t sits at 0x2000 + 0x80·t. Bit i enables source i, and bit 0 always reads zero.
- R9: The pending word is read-only. Writes to it are ignored.
- R10: Unmapped offsets read as zero, and writes to them change nothing.
- R11: A source with priority 0 never raises a target line and is never returned by a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | N_SRC | Level interrupt inputs; bit k is source k+1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers claim side effects) |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the current address |
| tgt_irq | output | NUM_TGT | Interrupt line per target |

## Verification
The bench sweeps all 256 combinations of active sources. For each combination it varies the priority pattern, the enable masks of both targets and the thresholds, and it checks the target lines and successive claims against an arithmetic model.

Several corner cases are targeted:
- A design that uses greater-or-equal at the threshold would raise a line at equality.
- A design that breaks ties toward higher identifiers would return the wrong source.
- A design that lets priority 0 compete would claim disabled sources.
- A gateway that does not wait for completion would re-pend a still-high level straight after a claim.
- A gateway that accepts identifier 0 or an out-of-range identifier would re-arm a source that was never completed.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;

    // Region bases and strides (byte offsets)
    localparam logic [23:0] PRIO_BASE  = 24'h000000;
    localparam logic [23:0] PEND_BASE  = 24'h001000;
    localparam logic [23:0] EN_BASE    = 24'h002000;
    localparam logic [23:0] EN_STRIDE  = 24'h000080;
    localparam logic [23:0] TGT_BASE   = 24'h200000;
    localparam logic [23:0] TGT_STRIDE = 24'h001000;
    localparam logic [23:0] CLAIM_OFS  = 24'h000004;

    typedef enum logic {
        GW_IDLE,
        GW_INFLIGHT
    } gw_state_e;

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_claim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic ready,
    input  logic complete,
    output logic valid,
    output logic busy
);

    gw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: REQUEST and COMPLETE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE:     if (level_in && ready) state_d = GW_INFLIGHT;
            GW_INFLIGHT: if (complete)          state_d = GW_IDLE;
            default:     state_d = GW_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        valid = 1'b0;
        busy  = 1'b0;
        unique case (state_q)
            GW_IDLE:     valid = level_in && ready;
            GW_INFLIGHT: busy  = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/irq_target_arb.sv
module irq_target_arb #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [N_SRC:0]             pend,
    input  logic [N_SRC:0]             en,
    input  logic [N_SRC:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]          thresh,
    output logic [ID_W-1:0]            best_id,
    output logic                       irq_out
);

    logic [PRIO_W-1:0] best_prio;

    // Ascending scan with strict compare: zero priority never wins, ties keep lowest id
    always_comb begin
        best_id   = '0;
        best_prio = '0;
        for (int i = 0; i <= N_SRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > best_prio)) begin
                best_prio = prio[i];
                best_id   = ID_W'(i);
            end
        end
        irq_out = best_prio > thresh;
    end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
    import irq_claim_pkg::*;
#(
    parameter int N_SRC    = 8,
    parameter int NUM_TGT  = 2,
    parameter int MAX_PRIO = 7,
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_irq,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_TGT-1:0] tgt_irq
);

    localparam int N_LVL  = (N_SRC < MAX_PRIO) ? N_SRC : MAX_PRIO;
    localparam int PRIO_W = $clog2(N_LVL + 1);
    localparam int ID_W   = $clog2(N_SRC + 1);

    logic [N_SRC:0][PRIO_W-1:0]   prio_q;
    logic [NUM_TGT-1:0][N_SRC:0]  en_q;
    logic [NUM_TGT-1:0][PRIO_W-1:0] thr_q;
    logic [N_SRC:0]               pend_q;
    logic [N_SRC:0]               gw_valid;
    logic [N_SRC:0]               gw_busy;
    logic [N_SRC:0]               claim_clr;
    logic [N_SRC:0]               compl;
    logic [NUM_TGT-1:0][ID_W-1:0] best_id;
    logic                         claim_wr_hit;

    // Address decode and read data
    always_comb begin
        reg_rdata    = '0;
        claim_clr    = '0;
        claim_wr_hit = 1'b0;
        for (int i = 1; i <= N_SRC; i++) begin
            if (reg_addr == ADDR_W'(PRIO_BASE + 24'(4 * i)))
                reg_rdata = DATA_W'(prio_q[i]);
        end
        if (reg_addr == ADDR_W'(PEND_BASE))
            reg_rdata = DATA_W'(pend_q);
        for (int t = 0; t < NUM_TGT; t++) begin
            if (reg_addr == ADDR_W'(EN_BASE + 24'(t) * EN_STRIDE))
                reg_rdata = DATA_W'(en_q[t]);
            if (reg_addr == ADDR_W'(TGT_BASE + 24'(t) * TGT_STRIDE))
                reg_rdata = DATA_W'(thr_q[t]);
            if (reg_addr == ADDR_W'(TGT_BASE + 24'(t) * TGT_STRIDE + CLAIM_OFS)) begin
                reg_rdata    = DATA_W'(best_id[t]);
                claim_wr_hit = reg_wr;
                if (reg_rd && (best_id[t] != '0))
                    claim_clr[best_id[t]] = 1'b1;
            end
        end
    end

    // Completion decode: only identifiers 1..N_SRC reach a gateway
    always_comb begin
        compl = '0;
        for (int i = 1; i <= N_SRC; i++)
            compl[i] = claim_wr_hit && (reg_wdata == DATA_W'(i));
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (reg_wr) begin
            for (int i = 1; i <= N_SRC; i++) begin
                if (reg_addr == ADDR_W'(PRIO_BASE + 24'(4 * i)))
                    prio_q[i] <= reg_wdata[PRIO_W-1:0];
            end
            for (int t = 0; t < NUM_TGT; t++) begin
                if (reg_addr == ADDR_W'(EN_BASE + 24'(t) * EN_STRIDE))
                    en_q[t] <= {reg_wdata[N_SRC:1], 1'b0};
                if (reg_addr == ADDR_W'(TGT_BASE + 24'(t) * TGT_STRIDE))
                    thr_q[t] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    // Pending bits: set by gateway request, cleared by claim
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~claim_clr) | gw_valid;
    end

    assign gw_valid[0] = 1'b0;
    assign gw_busy[0]  = 1'b0;

    for (genvar i = 1; i <= N_SRC; i++) begin : g_gw
        irq_gateway u_gw (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (src_irq[i-1]),
            .ready    (~pend_q[i]),
            .complete (compl[i]),
            .valid    (gw_valid[i]),
            .busy     (gw_busy[i])
        );
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_arb
        irq_target_arb #(
            .N_SRC  (N_SRC),
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_arb (
            .pend    (pend_q),
            .en      (en_q[t]),
            .prio    (prio_q),
            .thresh  (thr_q[t]),
            .best_id (best_id[t]),
            .irq_out (tgt_irq[t])
        );
    end

endmodule

// File: rtl/irq_claim_ctrl_chk.sv
module irq_claim_ctrl_chk
    import irq_claim_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int NUM_TGT = 2,
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [NUM_TGT-1:0] tgt_irq,
    input logic [N_SRC:0]     pend,
    input logic [N_SRC:0]     busy
);

    localparam int ID_W = $clog2(N_SRC + 1);

    logic at_claim;
    always_comb begin
        at_claim = 1'b0;
        for (int t = 0; t < NUM_TGT; t++)
            if (reg_addr == ADDR_W'(TGT_BASE + 24'(t) * TGT_STRIDE + CLAIM_OFS))
                at_claim = 1'b1;
    end

    // R6
    claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && at_claim && reg_rdata != '0) |=> !pend[$past(reg_rdata[ID_W-1:0])]);

    // R6
    empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && at_claim && reg_rdata == '0) |=> (($past(pend) & ~pend) == '0));

    // R5
    irq_has_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_irq != '0) |-> (pend != '0));

    for (genvar i = 1; i <= N_SRC; i++) begin : g_src
        // R3
        gateway_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $rose(busy[i]));

        // R7
        complete_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && at_claim && reg_wdata == DATA_W'(i)) |=> !busy[i]);
    end

endmodule

bind irq_claim_ctrl irq_claim_ctrl_chk #(
    .N_SRC   (N_SRC),
    .NUM_TGT (NUM_TGT),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tgt_irq   (tgt_irq),
    .pend      (pend_q),
    .busy      (gw_busy)
);

// File: tb/irq_claim_ctrl_tb.sv
module irq_claim_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src_irq = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [23:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NT-1:0] tgt_irq;

    int n_checks = 0;
    int n_errors = 0;

    int          prio_m [NS+1];
    logic [8:0]  en_m   [NT];
    int          thr_m  [NT];
    logic [8:0]  pend_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_claim_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tgt_irq(tgt_irq)
    );

    function automatic logic [23:0] a_prio(int i);  return 24'(4 * i); endfunction
    function automatic logic [23:0] a_en(int t);    return 24'h2000 + 24'(t * 'h80); endfunction
    function automatic logic [23:0] a_thr(int t);   return 24'h200000 + 24'(t * 'h1000); endfunction
    function automatic logic [23:0] a_claim(int t); return 24'h200004 + 24'(t * 'h1000); endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic int best_of(int t);
        int b = 0, bp = 0;
        for (int i = 1; i <= NS; i++)
            if (pend_m[i] && en_m[t][i] && prio_m[i] > bp) begin
                bp = prio_m[i]; b = i;
            end
        return b;
    endfunction

    task automatic claim_and_check(input int t, input string req);
        logic [31:0] d;
        int exp_id;
        exp_id = best_of(t);
        rd(a_claim(t), d);
        check(d == 32'(exp_id), req, $sformatf("claim target %0d", t), d, exp_id);
        if (exp_id != 0) pend_m[exp_id] = 1'b0;
    endtask

    task automatic check_irq(input string req);
        logic [NT-1:0] exp;
        for (int t = 0; t < NT; t++) begin
            int b = best_of(t);
            exp[t] = (b != 0) && (prio_m[b] > thr_m[t]);
        end
        #1 check(tgt_irq == exp, req, "tgt_irq", tgt_irq, exp);
    endtask

    task automatic drain_all();
        logic [31:0] d;
        src_irq = '0;
        for (int i = 1; i <= NS; i++) begin wr(a_prio(i), 32'd7); prio_m[i] = 7; end
        wr(a_en(0), 32'h1FE); en_m[0] = 9'h1FE;
        wr(a_thr(0), 32'd0);  thr_m[0] = 0;
        for (int k = 0; k <= NS; k++) rd(a_claim(0), d);
        for (int i = 1; i <= NS; i++) wr(a_claim(0), 32'(i));
        pend_m = '0;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i <= NS; i++) prio_m[i] = 0;
        en_m[0] = '0; en_m[1] = '0; thr_m[0] = 0; thr_m[1] = 0; pend_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check(tgt_irq == '0, "R1", "tgt_irq after reset", tgt_irq, 0);
        rd(a_prio(3), d);  check(d == 0, "R1", "priority after reset", d, 0);
        rd(24'h1000, d);   check(d == 0, "R1", "pending after reset", d, 0);
        rd(a_en(1), d);    check(d == 0, "R1", "enable after reset", d, 0);
        rd(a_thr(0), d);   check(d == 0, "R1", "threshold after reset", d, 0);
        rd(a_claim(0), d); check(d == 0, "R1", "claim after reset", d, 0);

        // R2 priority field width and slot 0
        for (int i = 1; i <= NS; i++) begin
            wr(a_prio(i), 32'hFFFF_FF00 | 32'(i * 3));
            rd(a_prio(i), d);
            check(d == 32'((i * 3) % 8), "R2", $sformatf("priority %0d readback", i), d, (i * 3) % 8);
        end
        wr(24'h0, 32'h7); rd(24'h0, d);
        check(d == 0, "R2", "slot 0 priority", d, 0);

        // R8 enable words, bit 0 forced to zero
        wr(a_en(0), 32'hFFFF_FFFF); rd(a_en(0), d);
        check(d == 32'h1FE, "R8", "enable t0 readback", d, 32'h1FE);
        wr(a_en(1), 32'h0000_00A5); rd(a_en(1), d);
        check(d == 32'hA4, "R8", "enable t1 readback", d, 32'hA4);
        rd(a_en(0), d);
        check(d == 32'h1FE, "R8", "enable t0 untouched by t1 write", d, 32'h1FE);

        // R10 unmapped offsets, R9 pending read-only
        wr(24'h1004, 32'hFFFF_FFFF); rd(24'h1004, d);
        check(d == 0, "R10", "unmapped 0x1004", d, 0);
        wr(24'h3000, 32'hFFFF_FFFF); rd(24'h3000, d);
        check(d == 0, "R10", "unmapped 0x3000", d, 0);
        wr(24'h200008, 32'h3); rd(24'h200008, d);
        check(d == 0, "R10", "unmapped 0x200008", d, 0);
        wr(24'h202000, 32'h3); rd(24'h202000, d);
        check(d == 0, "R10", "unmapped third target", d, 0);
        rd(a_thr(0), d);
        check(d == 0, "R10", "threshold unaffected by unmapped writes", d, 0);
        wr(24'h1000, 32'hFFFF_FFFF); rd(24'h1000, d);
        check(d == 0, "R9", "pending write ignored", d, 0);
        #1 check(tgt_irq == 0, "R9", "no line after pending write", tgt_irq, 0);

        // R5 threshold boundary, R4 tie break, R11 zero priority
        drain_all();
        wr(a_en(1), 32'h0);  en_m[1] = '0;
        for (int i = 1; i <= NS; i++) begin wr(a_prio(i), 32'd0); prio_m[i] = 0; end
        wr(a_prio(2), 32'd3); prio_m[2] = 3;
        wr(a_prio(5), 32'd3); prio_m[5] = 3;
        wr(a_thr(0), 32'd3);  thr_m[0] = 3;
        src_irq = 8'b0101_0010;      // sources 2, 5, 7 (7 has priority 0)
        pend_m = 9'b0_1010_0100;
        rd(24'h1000, d);
        check(d == 32'h0A4, "R3", "pending after raise", d, 32'h0A4);
        #1 check(tgt_irq[0] == 1'b0, "R5", "priority equal to threshold", tgt_irq[0], 0);
        wr(a_thr(0), 32'd2);  thr_m[0] = 2;
        #1 check(tgt_irq[0] == 1'b1, "R5", "priority above threshold", tgt_irq[0], 1);
        claim_and_check(0, "R4");   // expect 2 (tie -> lowest id)
        claim_and_check(0, "R4");   // expect 5
        #1 check(tgt_irq[0] == 1'b0, "R11", "priority-0 source raises nothing", tgt_irq[0], 0);
        claim_and_check(0, "R11");  // expect 0
        rd(24'h1000, d);
        check(d == 32'h080, "R6", "empty claim leaves pending", d, 32'h080);

        // R3/R7 gateway holds until completion
        rd(24'h1000, d);
        check(d[2] == 1'b0, "R3", "no re-request before completion", d[2], 0);
        wr(a_claim(0), 32'd0);
        wr(a_claim(1), 32'd9);
        rd(24'h1000, d);
        check(d[2] == 1'b0, "R7", "ids 0 and 9 ignored", d[2], 0);
        wr(a_claim(1), 32'd2);      // completion through another target's register
        rd(24'h1000, d);
        check(d[2] == 1'b1, "R7", "re-request after completion", d[2], 1);
        pend_m[2] = 1'b1;
        drain_all();

        // Sweep over all source masks
        for (int m = 0; m < 256; m++) begin
            for (int i = 1; i <= NS; i++) begin
                prio_m[i] = (i * 5 + m) % 8;
                wr(a_prio(i), 32'(prio_m[i]));
            end
            en_m[0] = (m % 3 == 0) ? 9'({(m ^ 'h5A) & 'hFF, 1'b0}) : 9'h1FE;
            en_m[1] = 9'({(m * 37) & 'hFF, 1'b0});
            thr_m[0] = m % 5;
            thr_m[1] = (m / 8) % 8;
            wr(a_en(0), 32'(en_m[0]));
            wr(a_en(1), 32'(en_m[1]));
            wr(a_thr(0), 32'(thr_m[0]));
            wr(a_thr(1), 32'(thr_m[1]));
            src_irq = 8'(m);
            pend_m = 9'({m[7:0], 1'b0});
            rd(24'h1000, d);
            check(d == 32'(pend_m), "R3", $sformatf("pending mask %0d", m), d, pend_m);
            check_irq("R5");
            claim_and_check(0, "R4");
            check_irq("R5");
            claim_and_check(1, "R6");
            claim_and_check(1, "R6");
            rd(24'h1000, d);
            check(d == 32'(pend_m), "R6", $sformatf("pending after claims mask %0d", m), d, pend_m);
            drain_all();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule